// File: doc/BRIEF.md
# Cluster Exchange Network

This block performs one bus transfer of an exchange network that joins `N_PE` processing elements (a power of two, at least 2). Each element holds a `WORD_W`-bit word. Every element offers its outgoing word on the P side and, in the same transfer, captures an incoming word on the Q side. A control vector shared by all elements picks the data flow. The source word can be broadcast to everyone. Whole words can rotate around the element ring. Every word can rotate by bits inside itself. Words can also be exchanged between elements whose indices differ by an XOR distance.

A transfer begins when `start` is high while `ready` is high. On that edge the block samples the P words, the control fields and the participation mask. The transfer then runs for a fixed number of clocks: two when `N_PE <= WORD_W`, otherwise three. At its last edge the Q registers of the participating elements are written, and `done` pulses for one cycle. `start` works as a valid with `ready` as its ready. While `ready` is low the block applies back-pressure: a `start` in that window is not queued, it is dropped, and the caller must hold or repeat the request until `ready` returns. Element `j` occupies bits `[j*WORD_W +: WORD_W]` of `p_flat` and `q_flat`.

Top module: `xnet_exchange`

## Requirements
- R1: During and after reset, before any transfer, every Q word is zero, `ready` is 1 and `done` is 0.
- R2: Mode 2'b00 (broadcast): every participating element `j` receives the word of element `ctl_src`.
- R3: Mode 2'b01 (word rotation): participating element `j` receives the word of element `(j - ctl_amt) mod N_PE`.
- R4: Mode 2'b10 (bit rotation): participating element `j` receives its own word rotated left by `ctl_amt mod WORD_W` bits (bit `i` moves to bit `(i + amt) mod WORD_W`).
- R5: Mode 2'b11 (reflection): participating element `j` receives the word of element `j XOR ctl_amt`, so elements `a` and `b` swap words in one transfer when `ctl_amt = a XOR b`.
- R6: Only elements whose bit `sel_mask[j]` is 1 at the accepting edge are written; the Q word of any other element keeps its previous value.
- R7: A transfer accepted at edge e0 lowers `ready` after e0. Its Q results and a one-cycle `done` pulse appear after edge e0+C-1, where C is 2 when `N_PE <= WORD_W` and 3 otherwise. `ready` is high again in the `done` cycle.
- R8: A `start` seen while `ready` is low is ignored. Changes to P, control or mask after the accepting edge do not alter the result or the timing of the transfer in progress.
- R9: The Q words change only in a `done` cycle and otherwise hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Transfer request (valid) |
| ready | output | 1 | Idle, a request is accepted this cycle |
| ctl_mode | input | 2 | 00 broadcast, 01 word rotate, 10 bit rotate, 11 reflect |
| ctl_src | input | IDX_W | Broadcast source element |
| ctl_amt | input | IDX_W | Rotation amount or reflection distance |
| sel_mask | input | N_PE | Participation mask, bit j for element j |
| p_flat | input | N_PE*WORD_W | Outgoing words of all elements |
| q_flat | output | N_PE*WORD_W | Captured incoming words of all elements |
| done | output | 1 | One-cycle pulse at the end of a transfer |

## Verification
A fault in the phase counter or busy flag shows up at the ports at once. `done` arrives one clock early or late, `ready` drops for the wrong length, or a request made during a transfer restarts it. Each of these is visible within the first transfer. A wrong sampled control field or mask shows in the Q words in the `done` cycle of the affected transfer. A wrong write enable shows as a Q word that changes outside a `done` cycle or on a masked element. The reference is compared every cycle, so each of these faults is caught no later than the cycle where it becomes visible.

// File: rtl/xnet_pkg.sv
package xnet_pkg;

  typedef enum logic [1:0] {
    XM_BCAST = 2'b00,
    XM_WROT  = 2'b01,
    XM_BROT  = 2'b10,
    XM_REFL  = 2'b11
  } xmode_e;

  // clocks per transfer from the ring size and word width
  function automatic int xfer_cycles(input int n_pe, input int word_w);
    return (n_pe <= word_w) ? 2 : 3;
  endfunction

endpackage

// File: rtl/xnet_seq.sv
module xnet_seq #(
  parameter int CYCLES = 2,
  localparam int CW = $clog2(CYCLES + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic ready,
  output logic load,
  output logic commit,
  output logic done
);

  logic          busy;
  logic [CW-1:0] phase;

  assign ready  = !busy;
  assign load   = start && !busy;
  assign commit = busy && (phase == CW'(CYCLES - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      busy  <= 1'b0;
      phase <= '0;
      done  <= 1'b0;
    end else begin
      done <= commit;
      if (load) begin
        busy  <= 1'b1;
        phase <= CW'(1);
      end else if (commit) begin
        busy  <= 1'b0;
        phase <= '0;
      end else if (busy) begin
        phase <= phase + CW'(1);
      end
    end
  end

endmodule

// File: rtl/xnet_router.sv
module xnet_router
  import xnet_pkg::*;
#(
  parameter int N_PE   = 8,
  parameter int WORD_W = 32,
  parameter int IDX_W  = 3
) (
  input  logic [N_PE*WORD_W-1:0] src_flat,
  input  xmode_e                 mode,
  input  logic [IDX_W-1:0]       sel_src,
  input  logic [IDX_W-1:0]       amt,
  output logic [N_PE*WORD_W-1:0] dst_flat
);

  logic [WORD_W-1:0] words [N_PE];

  for (genvar j = 0; j < N_PE; j++) begin : g_unpack
    assign words[j] = src_flat[j*WORD_W +: WORD_W];
  end

  for (genvar j = 0; j < N_PE; j++) begin : g_lane
    logic [IDX_W-1:0]    rot_idx;
    logic [IDX_W-1:0]    refl_idx;
    logic [2*WORD_W-1:0] dbl;
    logic [WORD_W-1:0]   sel;

    assign rot_idx  = IDX_W'(j) - amt;
    assign refl_idx = IDX_W'(j) ^ amt;

    always_comb begin
      dbl = {words[j], words[j]} << (int'(amt) % WORD_W);
    end

    always_comb begin
      unique case (mode)
        XM_BCAST: sel = words[sel_src];
        XM_WROT:  sel = words[rot_idx];
        XM_BROT:  sel = dbl[2*WORD_W-1:WORD_W];
        default:  sel = words[refl_idx];
      endcase
    end

    assign dst_flat[j*WORD_W +: WORD_W] = sel;
  end

endmodule

// File: rtl/xnet_qbank.sv
module xnet_qbank #(
  parameter int N_PE   = 8,
  parameter int WORD_W = 32
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   commit,
  input  logic [N_PE-1:0]        part,
  input  logic [N_PE*WORD_W-1:0] routed,
  output logic [N_PE*WORD_W-1:0] q_flat
);

  for (genvar j = 0; j < N_PE; j++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) begin
        q_flat[j*WORD_W +: WORD_W] <= '0;
      end else if (commit && part[j]) begin
        q_flat[j*WORD_W +: WORD_W] <= routed[j*WORD_W +: WORD_W];
      end
    end
  end

endmodule

// File: rtl/xnet_exchange.sv
module xnet_exchange
  import xnet_pkg::*;
#(
  parameter int N_PE   = 8,
  parameter int WORD_W = 32,
  localparam int IDX_W = $clog2(N_PE)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   start,
  output logic                   ready,
  input  logic [1:0]             ctl_mode,
  input  logic [IDX_W-1:0]       ctl_src,
  input  logic [IDX_W-1:0]       ctl_amt,
  input  logic [N_PE-1:0]        sel_mask,
  input  logic [N_PE*WORD_W-1:0] p_flat,
  output logic [N_PE*WORD_W-1:0] q_flat,
  output logic                   done
);

  localparam int CYC = xfer_cycles(N_PE, WORD_W);

  logic                   load;
  logic                   commit;
  logic [N_PE*WORD_W-1:0] p_hold;
  logic [N_PE*WORD_W-1:0] routed;
  xmode_e                 mode_hold;
  logic [IDX_W-1:0]       src_hold;
  logic [IDX_W-1:0]       amt_hold;
  logic [N_PE-1:0]        mask_hold;

  xnet_seq #(.CYCLES(CYC)) u_seq (
    .clk    (clk),
    .rst    (rst),
    .start  (start),
    .ready  (ready),
    .load   (load),
    .commit (commit),
    .done   (done)
  );

  // request sampled once, at the accepting edge
  always_ff @(posedge clk) begin
    if (rst) begin
      p_hold    <= '0;
      mode_hold <= XM_BCAST;
      src_hold  <= '0;
      amt_hold  <= '0;
      mask_hold <= '0;
    end else if (load) begin
      p_hold    <= p_flat;
      mode_hold <= xmode_e'(ctl_mode);
      src_hold  <= ctl_src;
      amt_hold  <= ctl_amt;
      mask_hold <= sel_mask;
    end
  end

  xnet_router #(.N_PE(N_PE), .WORD_W(WORD_W), .IDX_W(IDX_W)) u_router (
    .src_flat (p_hold),
    .mode     (mode_hold),
    .sel_src  (src_hold),
    .amt      (amt_hold),
    .dst_flat (routed)
  );

  xnet_qbank #(.N_PE(N_PE), .WORD_W(WORD_W)) u_qbank (
    .clk    (clk),
    .rst    (rst),
    .commit (commit),
    .part   (mask_hold),
    .routed (routed),
    .q_flat (q_flat)
  );

endmodule

// File: rtl/xnet_chk.sv
module xnet_chk #(
  parameter int QW     = 256,
  parameter int CYCLES = 2
) (
  input logic          clk,
  input logic          rst,
  input logic          start,
  input logic          ready,
  input logic          done,
  input logic [QW-1:0] q_flat
);

  logic [2:0] span;

  always_ff @(posedge clk) begin
    if (rst) span <= '0;
    else if (ready && start) span <= 3'd1;
    else if (!ready) span <= span + 3'd1;
  end

  a_r7_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r7_busy_after_accept: assert property (@(posedge clk) disable iff (rst)
    (ready && start) |=> !ready);

  a_r7_ready_at_done: assert property (@(posedge clk) disable iff (rst)
    done |-> ready);

  a_r7_span: assert property (@(posedge clk) disable iff (rst)
    done |-> (span == 3'(CYCLES)));

  a_r9_q_only_at_done: assert property (@(posedge clk) disable iff (rst)
    !$stable(q_flat) |-> done);

endmodule

bind xnet_exchange xnet_chk #(.QW(N_PE*WORD_W), .CYCLES(CYC)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .start  (start),
  .ready  (ready),
  .done   (done),
  .q_flat (q_flat)
);

// File: tb/xnet_exchange_test.sv
module xnet_exchange_test;

  localparam int N  = 8;
  localparam int W  = 32;
  localparam int NW = 4;
  localparam int CYC = 2;

  logic           clk = 0;
  logic           rst = 1;
  logic           start = 0;
  logic [1:0]     ctl_mode = 0;
  logic [2:0]     ctl_src = 0;
  logic [2:0]     ctl_amt = 0;
  logic [N-1:0]   sel_mask = 0;
  logic [N*W-1:0] p_in = 0;
  logic [N*W-1:0] q_out;
  logic           ready, done;

  logic            n_start = 0;
  logic [N*NW-1:0] n_p = 0;
  logic [N*NW-1:0] n_q;
  logic            n_ready, n_done;

  int checks = 0;
  int errors = 0;
  int cyc_cnt = 0;

  always #10 clk = ~clk;

  xnet_exchange #(.N_PE(N), .WORD_W(W)) uut (
    .clk(clk), .rst(rst), .start(start), .ready(ready),
    .ctl_mode(ctl_mode), .ctl_src(ctl_src), .ctl_amt(ctl_amt),
    .sel_mask(sel_mask), .p_flat(p_in), .q_flat(q_out), .done(done)
  );

  xnet_exchange #(.N_PE(N), .WORD_W(NW)) uut_narrow (
    .clk(clk), .rst(rst), .start(n_start), .ready(n_ready),
    .ctl_mode(ctl_mode), .ctl_src(ctl_src), .ctl_amt(ctl_amt),
    .sel_mask(sel_mask), .p_flat(n_p), .q_flat(n_q), .done(n_done)
  );

  // behavioural reference for the wide instance
  logic [W-1:0] mq [N];
  logic [W-1:0] lp [N];
  logic [1:0]   lmode;
  logic [2:0]   lsrc, lamt;
  logic [N-1:0] lmask;
  bit           mbusy, mdone;
  int           mph;

  function automatic string mode_tag(input logic [1:0] m);
    case (m)
      2'b00:   return "R2";
      2'b01:   return "R3";
      2'b10:   return "R4";
      default: return "R5";
    endcase
  endfunction

  always @(posedge clk) begin
    cyc_cnt++;
    if (rst) begin
      foreach (mq[j]) mq[j] = '0;
      mbusy = 0; mdone = 0; mph = 0;
    end else begin
      mdone = 0;
      if (!mbusy && start) begin
        for (int j = 0; j < N; j++) lp[j] = p_in[j*W +: W];
        lmode = ctl_mode; lsrc = ctl_src; lamt = ctl_amt; lmask = sel_mask;
        mbusy = 1; mph = 1;
      end else if (mbusy) begin
        if (mph == CYC - 1) begin
          for (int j = 0; j < N; j++) begin
            logic [W-1:0] nv;
            case (lmode)
              2'b00:   nv = lp[lsrc];
              2'b01:   nv = lp[(j - int'(lamt)) & (N - 1)];
              2'b10:   nv = (lp[j] << lamt) | (lp[j] >> (W - int'(lamt)));
              default: nv = lp[j ^ int'(lamt)];
            endcase
            if (lmask[j]) mq[j] = nv;
          end
          mbusy = 0; mdone = 1; mph = 0;
        end else begin
          mph++;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      checks++;
      if (ready !== !mbusy || done !== mdone) begin
        errors++;
        $display("FAIL R7/R8 handshake: ready=%0b done=%0b expected ready=%0b done=%0b",
                 ready, done, !mbusy, mdone);
      end
      for (int j = 0; j < N; j++) begin
        checks++;
        if (q_out[j*W +: W] !== mq[j]) begin
          errors++;
          $display("FAIL %s/R6/R9 element %0d: got %h expected %h",
                   mode_tag(lmode), j, q_out[j*W +: W], mq[j]);
        end
      end
    end
  end

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic load_p(input int seed);
    for (int j = 0; j < N; j++)
      p_in[j*W +: W] = 32'h9E37_79B9 * (seed * 16 + j + 1) ^ (32'h1 << j);
  endtask

  task automatic xfer(input logic [1:0] m, input logic [2:0] s, input logic [2:0] a,
                      input logic [N-1:0] mk);
    @(negedge clk);
    ctl_mode = m; ctl_src = s; ctl_amt = a; sel_mask = mk; start = 1;
    @(negedge clk);
    start = 0;
    for (int i = 0; i < 10 && !done; i++) @(negedge clk);
  endtask

  initial begin
    logic [W-1:0] keep7, w0, w5;
    int n;
    repeat (3) @(negedge clk);
    // R1 in reset
    chk("R1 q0", q_out[0 +: W], '0);
    chk("R1 ready", {31'b0, ready}, 32'd1);
    rst = 0;
    @(negedge clk);
    chk("R1 q7", q_out[7*W +: W], '0);
    chk("R1 done", {31'b0, done}, 32'd0);

    // R2 broadcast
    load_p(1);
    xfer(2'b00, 3'd2, 3'd0, 8'hFF);
    chk("R2 bcast q5", q_out[5*W +: W], p_in[2*W +: W]);

    // R3 word rotation
    for (int a = 0; a < N; a += 3) begin
      load_p(2 + a);
      xfer(2'b01, 3'd0, 3'(a), 8'hFF);
    end
    load_p(9);
    xfer(2'b01, 3'd0, 3'd1, 8'hFF);
    chk("R3 rot q0", q_out[0 +: W], p_in[7*W +: W]);

    // R4 bit rotation
    for (int a = 0; a < N; a += 2) begin
      load_p(20 + a);
      xfer(2'b10, 3'd0, 3'(a), 8'hFF);
    end
    load_p(30);
    xfer(2'b10, 3'd0, 3'd4, 8'hFF);
    chk("R4 brot q3", q_out[3*W +: W],
        {p_in[3*W +: W][27:0], p_in[3*W +: W][31:28]});

    // R5 reflection swap of 0 and 5
    load_p(40);
    w0 = p_in[0 +: W]; w5 = p_in[5*W +: W];
    xfer(2'b11, 3'd0, 3'd5, 8'hFF);
    chk("R5 swap q0", q_out[0 +: W], w5);
    chk("R5 swap q5", q_out[5*W +: W], w0);

    // R6 partial mask
    keep7 = q_out[7*W +: W];
    load_p(50);
    xfer(2'b01, 3'd0, 3'd2, 8'h0F);
    chk("R6 masked q7", q_out[7*W +: W], keep7);
    xfer(2'b00, 3'd6, 3'd0, 8'hA5);

    // R8 start and input change while busy
    load_p(60);
    @(negedge clk);
    ctl_mode = 2'b11; ctl_amt = 3'd0; sel_mask = 8'hFF; start = 1;
    w0 = p_in[0 +: W];
    @(negedge clk);
    chk("R8 busy", {31'b0, ready}, 32'd0);
    ctl_mode = 2'b00; ctl_src = 3'd3; load_p(61);
    @(negedge clk);
    start = 0;
    chk("R8 done on time", {31'b0, done}, 32'd1);
    chk("R8 first request result", q_out[0 +: W], w0);
    @(negedge clk);
    chk("R8 no restart", {31'b0, ready}, 32'd1);

    // R7 three-clock transfer on the narrow instance
    for (int j = 0; j < N; j++) n_p[j*NW +: NW] = 4'(j);
    @(negedge clk);
    ctl_mode = 2'b11; ctl_amt = 3'd3; sel_mask = 8'hFF; n_start = 1;
    @(negedge clk);
    n_start = 0;
    n = 1;
    while (!n_done && n < 10) begin @(negedge clk); n++; end
    chk("R7 narrow length", 32'(n), 32'd3);
    chk("R5 narrow refl q1", 32'(n_q[1*NW +: NW]), 32'd2);
    chk("R7 narrow ready", {31'b0, n_ready}, 32'd1);

    repeat (3) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    wait (cyc_cnt > 20000);
    errors++;
    $display("FAIL R7 watchdog: run did not complete");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule